// File: doc/BRIEF.md
# Ethernet MII Receive Frame Checker

This block sits behind a 4-bit MII receive interface. It works through one frame at a time. First it hunts for the run of preamble nibbles and the start-of-frame delimiter. After that it pairs the incoming nibbles into bytes, low nibble first, and writes each byte to a downstream receive FIFO. The write is qualified by the FIFO's full flag in the same cycle.

While data arrives, the block does three things:
- It folds every whole byte into a CRC-32 check.
- It counts the bytes against a programmable maximum length.
- It holds back any trailing half byte.

When the data-valid signal drops, the block writes one status word to the FIFO, tagged as end of frame. The word carries a saturating length and five error flags.

Flag rules:
- A frame longer than the programmable maximum is flagged, raises a one-cycle babbling-receive pulse, and is still stored.
- Storage stops only at a fixed 2047-byte ceiling.
- If a byte meets a full FIFO, the rest of that frame is dropped. The status word waits until space returns. Any frame that starts during that wait is ignored.

Top module: `mii_rx_checker`

## Requirements
- R1: A frame is one or more nibbles of value 0x5 followed by nibble 0xD while `rx_dv` is high; each following pair of nibbles forms one byte (first nibble in bits 3:0, second in bits 7:4), written as a FIFO entry with `fifo_data[7:0]` = byte, `fifo_data[15:8]` = 0 and `fifo_eof` = 0, in arrival order.
- R2: A frame whose first nibble is not 0x5, whose hunt sees any other nibble, or whose `rx_dv` drops before the 0xD nibble produces no FIFO entry at all.
- R3: After `rx_dv` falls on a frame that passed the delimiter, exactly one entry with `fifo_eof` = 1 is written. Its layout is: bits 10:0 the byte count (saturated at 2047), bit 11 TR, bit 12 LG, bit 13 CR, bit 14 NO, bit 15 OV.
- R4: The CRC-32 (reflected polynomial 0x04C11DB7, preset all ones) runs over all whole bytes including the FCS. A matching frame reports CR = 0 and NO = 0. A mismatch with an even nibble count reports CR = 1 and NO = 0.
- R5: A trailing odd nibble is excluded from both the CRC and the byte count. With a mismatch it reports NO = 1 and CR = 0; with a match no flag is set.
- R6: When the byte count exceeds `max_len`, LG = 1 and `babble_irq` is high for exactly one cycle per frame; the bytes are still stored.
- R7: Bytes beyond the 2047th are not written, TR = 1, and the length field reads 2047.
- R8: `fifo_wr` is never high while `fifo_full` is high. A byte that meets a full FIFO sets OV, and no later byte of that frame is written. The status word is written once `fifo_full` is low.
- R9: A frame that starts while a status word is still waiting for space produces no entries.
- R10: During and right after reset, `fifo_wr` and `babble_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, equal to the MII receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | MII receive data valid |
| rx_nib | input | 4 | MII receive nibble |
| max_len | input | 11 | Programmable maximum frame length in bytes |
| fifo_full | input | 1 | Downstream FIFO cannot accept an entry this cycle |
| fifo_wr | output | 1 | Write strobe, qualified by `fifo_full` |
| fifo_data | output | 16 | Data byte or status word |
| fifo_eof | output | 1 | Entry is the status word |
| babble_irq | output | 1 | One-cycle pulse when a frame passes `max_len` |

## Verification
Assertions check the following on every cycle:
- No write is made into a full FIFO.
- No data byte is written after overrun.
- A pending status word stays stable while the FIFO is full.
- NO and CR never appear together.
- The babbling pulse lasts one cycle.
- A byte only appears after the delimiter.

Only the directed scenarios can show the rest:
- Byte values and their order.
- The CRC verdict on good, corrupted and odd-nibble frames.
- The exact length field.
- The 2047-byte truncation point.
- Silent dropping of runt frames, and of frames that arrive while a status word waits.

// File: rtl/mii_rx_pkg.sv
// Package: shared widths, status word layout and the byte-wise CRC step.
// Assumes reflected CRC-32 with the register shifted towards bit 0.
package mii_rx_pkg;

    localparam int LEN_W      = 11;
    localparam int ENTRY_W    = 16;
    localparam int MAX_STORE  = (1 << LEN_W) - 1;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    // Status word: flags on top, length at the bottom
    typedef struct packed {
        logic             ov;
        logic             no;
        logic             cr;
        logic             lg;
        logic             tr;
        logic [LEN_W-1:0] len;
    } rx_status_t;

    // Advances the reflected CRC register by one byte, bit 0 first
    function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            c = (c[0] ^ b[i]) ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_rx_framer.sv
// Framer: hunts preamble nibbles and the delimiter, packs nibbles into bytes
// (low nibble first) and reports the end of frame with an odd-nibble flag.
// Assumes one nibble per clock while rx_dv is high. All outputs are registered.
module mii_rx_framer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic [3:0] rx_nib,
    input  logic       hold,
    output logic       sof,
    output logic       byte_vld,
    output logic [7:0] byte_out,
    output logic       frame_end,
    output logic       dribble
);

    typedef enum logic [1:0] {S_IDLE, S_HUNT, S_DATA, S_DROP} fr_state_t;

    fr_state_t  state_q;
    logic       phase_q;
    logic [3:0] low_q;

    // Frame state machine and nibble pairing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            phase_q   <= 1'b0;
            low_q     <= '0;
            sof       <= 1'b0;
            byte_vld  <= 1'b0;
            byte_out  <= '0;
            frame_end <= 1'b0;
            dribble   <= 1'b0;
        end else begin
            sof       <= 1'b0;
            byte_vld  <= 1'b0;
            frame_end <= 1'b0;
            unique case (state_q)
                S_IDLE: if (rx_dv) begin
                    state_q <= (!hold && rx_nib == 4'h5) ? S_HUNT : S_DROP;
                end
                S_HUNT: begin
                    if (!rx_dv) begin
                        state_q <= S_IDLE;
                    end else if (rx_nib == 4'hD) begin
                        state_q <= S_DATA;
                        sof     <= 1'b1;
                        phase_q <= 1'b0;
                    end else if (rx_nib != 4'h5) begin
                        state_q <= S_DROP;
                    end
                end
                S_DATA: begin
                    if (!rx_dv) begin
                        state_q   <= S_IDLE;
                        frame_end <= 1'b1;
                        dribble   <= phase_q;
                    end else if (!phase_q) begin
                        low_q   <= rx_nib;
                        phase_q <= 1'b1;
                    end else begin
                        byte_out <= {rx_nib, low_q};
                        byte_vld <= 1'b1;
                        phase_q  <= 1'b0;
                    end
                end
                default: if (!rx_dv) state_q <= S_IDLE;
            endcase
        end
    end

    // R1: a byte strobe only follows a cycle spent in the data state
    p_byte_in_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(state_q) == S_DATA);

    // R3: the end marker never coincides with a byte strobe
    p_end_not_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !byte_vld);

endmodule

// File: rtl/mii_rx_crc.sv
// CRC checker: preset at start of frame, advanced once per whole byte.
// crc_ok is high when the register holds the good-frame residue.
module mii_rx_crc
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       crc_ok
);

    logic [31:0] crc_q;

    // CRC register update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc_q <= '1;
        else if (byte_vld) crc_q <= crc_byte(crc_q, byte_in);
    end

    assign crc_ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/mii_rx_checker.sv
// Top: counts bytes, decides storage, overrun and truncation, builds the
// status word and writes data and status into the downstream FIFO.
// Assumes fifo_full is valid in the same cycle as fifo_wr and that max_len
// is stable during a frame.
module mii_rx_checker
    import mii_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_dv,
    input  logic [3:0]         rx_nib,
    input  logic [LEN_W-1:0]   max_len,
    input  logic               fifo_full,
    output logic               fifo_wr,
    output logic [ENTRY_W-1:0] fifo_data,
    output logic               fifo_eof,
    output logic               babble_irq
);

    localparam int CNT_W = LEN_W + 1;

    logic             sof, byte_vld, frame_end, dribble, crc_ok;
    logic [7:0]       byte_b;
    logic [CNT_W-1:0] cnt_q;
    logic             ov_q, pend_q, irq_q;
    rx_status_t       stat_q, stat_c;
    logic             store_ok;

    mii_rx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib), .hold(pend_q),
        .sof(sof), .byte_vld(byte_vld), .byte_out(byte_b),
        .frame_end(frame_end), .dribble(dribble)
    );

    mii_rx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clr(sof), .byte_vld(byte_vld),
        .byte_in(byte_b), .crc_ok(crc_ok)
    );

    assign store_ok = !ov_q && (cnt_q < CNT_W'(MAX_STORE));

    // Status word assembly from the finished frame
    always_comb begin
        stat_c.tr  = cnt_q > CNT_W'(MAX_STORE);
        stat_c.len = stat_c.tr ? LEN_W'(MAX_STORE) : cnt_q[LEN_W-1:0];
        stat_c.lg  = cnt_q > {1'b0, max_len};
        stat_c.cr  = !crc_ok && !dribble;
        stat_c.no  = !crc_ok && dribble;
        stat_c.ov  = ov_q;
    end

    // Byte counting, overrun capture, status hold and interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ov_q   <= 1'b0;
            pend_q <= 1'b0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= byte_vld && (cnt_q == {1'b0, max_len});
            if (sof) begin
                cnt_q <= '0;
                ov_q  <= 1'b0;
            end else if (byte_vld) begin
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                if (store_ok && fifo_full) ov_q <= 1'b1;
            end
            if (frame_end) begin
                pend_q <= 1'b1;
                stat_q <= stat_c;
            end else if (pend_q && !fifo_full) begin
                pend_q <= 1'b0;
            end
        end
    end

    // FIFO write mux: status when pending, otherwise the stored byte
    always_comb begin
        fifo_wr   = !fifo_full && (pend_q || (byte_vld && store_ok));
        fifo_eof  = pend_q;
        fifo_data = pend_q ? ENTRY_W'(stat_q) : {{(ENTRY_W-8){1'b0}}, byte_b};
    end

    assign babble_irq = irq_q;

    // R8: never write into a full FIFO
    p_no_write_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    // R8: once overrun is seen no data byte reaches the FIFO
    p_no_data_after_ov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_q |-> !(fifo_wr && !fifo_eof));

    // R8: a waiting status word stays put while the FIFO is full
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && fifo_full) |=> (pend_q && $stable(stat_q)));

    // R5: non-octet and CRC flags are mutually exclusive
    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_eof |-> !(fifo_data[13] && fifo_data[14]));

    // R6: the babbling pulse lasts one cycle
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |=> !babble_irq);

endmodule

// File: tb/mii_rx_checker_tb.sv
`timescale 1ns/100ps
// Directed bench: one task per scenario, results checked inside each task.
module mii_rx_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_dv = 1'b0;
    logic [3:0]  rx_nib = '0;
    logic [10:0] max_len = 11'd1518;
    logic        fifo_full = 1'b0;
    logic        fifo_wr, fifo_eof, babble_irq;
    logic [15:0] fifo_data;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic [7:0]  tx_q[$];
    logic [7:0]  got_data[$];
    logic [15:0] got_stat[$];
    int          irq_cnt = 0;
    int          bad_hi = 0;

    always #2.5 clk = ~clk;

    mii_rx_checker dut_i (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
        .max_len(max_len), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .fifo_eof(fifo_eof), .babble_irq(babble_irq)
    );

    // Collector: samples the FIFO side at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && fifo_wr) begin
            if (fifo_eof) got_stat.push_back(fifo_data);
            else begin
                got_data.push_back(fifo_data[7:0]);
                if (fifo_data[15:8] != 8'h00) bad_hi++;
            end
        end
        if (rst_n && babble_irq) irq_cnt++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic nib(input logic [3:0] v);
        rx_dv = 1'b1; rx_nib = v; tick(1);
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] != b[k]) r = {1'b0, r[31:1]} ^ 32'hEDB88320;
            else r = {1'b0, r[31:1]};
        end
        return r;
    endfunction

    // Payload of n bytes plus FCS, optionally with a flipped bit
    task automatic build(input int n, input int seed, input bit corrupt);
        logic [31:0] c = 32'hFFFFFFFF;
        tx_q.delete();
        for (int i = 0; i < n; i++) tx_q.push_back(8'((seed + i * 13) & 255));
        foreach (tx_q[i]) c = ref_crc(c, tx_q[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) tx_q.push_back(c[8*i +: 8]);
        if (corrupt) tx_q[2] = tx_q[2] ^ 8'h10;
    endtask

    task automatic clear_obs();
        got_data.delete(); got_stat.delete(); irq_cnt = 0; bad_hi = 0;
    endtask

    // Sends preamble, delimiter, tx_q and an optional trailing nibble
    task automatic send(input bit odd, input logic [3:0] extra);
        for (int i = 0; i < 15; i++) nib(4'h5);
        nib(4'hD);
        foreach (tx_q[i]) begin nib(tx_q[i][3:0]); nib(tx_q[i][7:4]); end
        if (odd) nib(extra);
        rx_dv = 1'b0; rx_nib = '0;
        tick(8);
    endtask

    task automatic cmp_data(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n && i < got_data.size(); i++)
            if (got_data[i] != tx_q[i]) bad++;
        check(bad == 0 && bad_hi == 0, req, bad, 0);
    endtask

    task automatic expect_status(input int len, input logic [4:0] flags, input string req);
        check(got_stat.size() == 1, {req, " status count"}, got_stat.size(), 1);
        if (got_stat.size() == 1) begin
            check(got_stat[0][10:0] == 11'(len), {req, " length"}, got_stat[0][10:0], len);
            check(got_stat[0][15:11] == flags, {req, " flags"}, got_stat[0][15:11], flags);
        end
    endtask

    task automatic t_reset();
        check(fifo_wr == 1'b0, "R10 fifo_wr in reset", fifo_wr, 0);
        check(babble_irq == 1'b0, "R10 irq in reset", babble_irq, 0);
    endtask

    task automatic t_good();
        clear_obs(); build(60, 3, 0); send(0, 4'h0);
        check(got_data.size() == 64, "R1 data count", got_data.size(), 64);
        cmp_data(64, "R1 data bytes");
        expect_status(64, 5'b00000, "R3 R4 good frame");
        check(irq_cnt == 0, "R6 no irq", irq_cnt, 0);
    endtask

    task automatic t_bad_crc();
        clear_obs(); build(46, 9, 1); send(0, 4'h0);
        expect_status(50, 5'b00100, "R4 CRC error");
    endtask

    task automatic t_dribble_good();
        clear_obs(); build(46, 21, 0); send(1, 4'hA);
        check(got_data.size() == 50, "R5 odd nibble not stored", got_data.size(), 50);
        expect_status(50, 5'b00000, "R5 dribble good");
    endtask

    task automatic t_dribble_bad();
        clear_obs(); build(46, 33, 1); send(1, 4'h3);
        expect_status(50, 5'b01000, "R5 dribble bad");
    endtask

    task automatic t_runt();
        clear_obs();
        for (int i = 0; i < 10; i++) nib(4'h5);
        rx_dv = 1'b0; tick(6);
        nib(4'h7); for (int i = 0; i < 10; i++) nib(4'hD);
        rx_dv = 1'b0; tick(6);
        for (int i = 0; i < 4; i++) nib(4'h5);
        nib(4'h9); nib(4'hD); for (int i = 0; i < 8; i++) nib(4'h1);
        rx_dv = 1'b0; tick(6);
        check(got_data.size() + got_stat.size() == 0, "R2 runt dropped",
              got_data.size() + got_stat.size(), 0);
    endtask

    task automatic t_long();
        clear_obs(); max_len = 11'd20; build(26, 5, 0); send(0, 4'h0);
        check(got_data.size() == 30, "R6 long frame stored", got_data.size(), 30);
        expect_status(30, 5'b00010, "R6 length flag");
        check(irq_cnt == 1, "R6 irq pulse count", irq_cnt, 1);
        max_len = 11'd1518;
    endtask

    task automatic t_trunc();
        clear_obs(); build(2100, 7, 0); send(0, 4'h0);
        check(got_data.size() == 2047, "R7 stored bytes", got_data.size(), 2047);
        cmp_data(2047, "R7 stored prefix");
        expect_status(2047, 5'b00011, "R7 truncation");
        check(irq_cnt == 1, "R7 irq once", irq_cnt, 1);
    endtask

    task automatic t_overrun();
        int nd;
        clear_obs(); build(96, 11, 0);
        fork
            send(0, 4'h0);
            begin
                wait (got_data.size() >= 20);
                @(posedge clk); #1 fifo_full = 1'b1;
            end
        join
        nd = got_data.size();
        check(got_stat.size() == 0, "R8 status waits for space", got_stat.size(), 0);
        build(30, 50, 0); send(0, 4'h0);
        check(got_data.size() == nd, "R9 frame during wait ignored", got_data.size(), nd);
        fifo_full = 1'b0; tick(3);
        check(nd >= 20 && nd < 40, "R8 data stopped at overrun", nd, 20);
        build(96, 11, 0);
        cmp_data(nd, "R8 prefix before overrun");
        expect_status(100, 5'b10000, "R8 overrun");
        check(got_data.size() == nd, "R8 no data after space returns", got_data.size(), nd);
        clear_obs(); build(40, 77, 0); send(0, 4'h0);
        check(got_data.size() == 44, "R9 next frame accepted", got_data.size(), 44);
        expect_status(44, 5'b00000, "R9 next frame status");
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait (cycles > 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        tick(2);
        t_reset();
        @(posedge clk); #1 rst_n = 1'b1;
        tick(2);
        t_reset();
        t_good();
        t_bad_crc();
        t_dribble_good();
        t_dribble_bad();
        t_runt();
        t_long();
        t_trunc();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule